// File: doc/BRIEF.md
# Multidrop UART Receiver with Address Wakeup

This block receives asynchronous serial characters on a shared multidrop line. Every character carries a ninth control bit, the multiprocessor bit, which tells address characters (bit set) apart from data characters (bit clear). The RX line is synchronised and oversampled at OVS ticks per bit. The start bit is confirmed at its middle and every later bit is sampled at its centre. Each accepted byte is moved into a holding data register, and ready, framing-error and overrun flags are updated. Interrupt requests follow those flags when the receive interrupt enable is set.

A node that only listens for its own address sets the wakeup enable. While the wakeup enable is set and multiprocessor mode is on, every character whose multiprocessor bit is clear is dropped whole: nothing is transferred, no error is detected, no flag is set and no interrupt is raised. The first character with the multiprocessor bit set clears the wakeup enable in hardware and is processed like any other character, so software can then read the address and decide whether to stay awake.

The host clears the flags with a one-cycle clear strobe. It sets the wakeup enable with a one-cycle strobe, and that setting governs characters from the next frame on.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, data_o is 0x00 and ready_o, fer_o, ovr_o, mpb_o, wake_en_o, rxi_o and eri_o are all 0.
- R2: A frame is one low start bit, 8 data bits sent least significant bit first, one multiprocessor bit and one high stop bit, each OVS ticks long. A good frame loads data_o with the byte and sets ready_o. A low pulse shorter than half a bit does not start a frame.
- R3: While rx_en_i is 0 no frame starts. data_o, ready_o, fer_o and ovr_o keep their values and are not cleared by the disable.
- R4: A frame whose stop bit samples as 0 sets fer_o, does not set ready_o and leaves data_o unchanged.
- R5: A good frame that completes while ready_o is 1 sets ovr_o and leaves data_o unchanged.
- R6: A one-cycle pulse on clr_flags_i clears ready_o, fer_o and ovr_o on the next clock.
- R7: While the wakeup enable is in effect and mp_mode_i is 1, a character with multiprocessor bit 0 leaves data_o, ready_o, fer_o, ovr_o and mpb_o unchanged, even if its stop bit is bad.
- R8: A character with multiprocessor bit 1 received while the wakeup enable is in effect clears wake_en_o and sets mpb_o to 1. It is then transferred and flagged like a normal character. wake_en_o falls only on such a character.
- R9: With mp_mode_i at 0 the wakeup enable has no effect: characters with multiprocessor bit 0 are accepted and wake_en_o stays 1.
- R10: A wake_set_i pulse sets wake_en_o on the next clock. If the pulse arrives while a frame is in progress, that frame is still accepted, and filtering starts with the following frame.
- R11: rxi_o equals rie_i AND ready_o, and eri_o equals rie_i AND (fer_o OR ovr_o).
- R12: mpb_o takes the multiprocessor bit of every accepted character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| tick_i | input | 1 | Oversampling tick, OVS per bit time |
| rx_en_i | input | 1 | Receive enable |
| mp_mode_i | input | 1 | Multiprocessor mode |
| wake_set_i | input | 1 | One-cycle strobe that sets the wakeup enable |
| rie_i | input | 1 | Receive and error interrupt enable |
| clr_flags_i | input | 1 | One-cycle strobe that clears ready, framing and overrun flags |
| data_o | output | 8 | Receive data register |
| ready_o | output | 1 | Receive data ready flag |
| fer_o | output | 1 | Framing error flag |
| ovr_o | output | 1 | Overrun flag |
| mpb_o | output | 1 | Multiprocessor bit of the last accepted character |
| wake_en_o | output | 1 | Wakeup enable state |
| rxi_o | output | 1 | Receive interrupt request |
| eri_o | output | 1 | Error interrupt request |

## Verification
The bench builds the receiver with OVS set to 8 and SYNC_STAGES left at 2, with tick_i held high every clock. One frame therefore lasts 88 clocks. This makes it cheap to run long chains of frames, where wakeup, overrun and disable effects only show up across several characters. With a short bit time, a start glitch of two clocks falls clearly under half a bit, and a wakeup strobe can be placed inside a known data bit of a frame in flight.

// File: rtl/mpu_rx_pkg.sv
package mpu_rx_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_MPB,
    ST_STOP
  } rx_st_e;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              mpb;
    logic              stop_ok;
  } rx_char_t;
endpackage

// File: rtl/mpu_rx_sync.sv
module mpu_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/mpu_rx_frame.sv
module mpu_rx_frame
  import mpu_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     rx_i,
  input  logic     tick_i,
  input  logic     en_i,
  output logic     start_o,
  output logic     done_o,
  output rx_char_t char_o
);
  localparam int CW   = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int BW   = $clog2(CHAR_W);
  localparam int HALF = OVS / 2 - 1;

  rx_st_e            st_q;
  logic [CW-1:0]     cnt_q;
  logic [BW-1:0]     idx_q;
  logic [CHAR_W-1:0] sh_q;
  logic              mpb_q;
  logic              stop_q;
  logic              bit_end;

  assign bit_end = tick_i && (cnt_q == CW'(OVS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      mpb_q   <= 1'b0;
      stop_q  <= 1'b0;
      start_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      start_o <= 1'b0;
      done_o  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (tick_i && en_i && !rx_i) begin
            st_q  <= ST_START;
            cnt_q <= '0;
          end
        end
        ST_START: begin
          if (tick_i) begin
            if (cnt_q == CW'(HALF)) begin
              cnt_q <= '0;
              if (!rx_i) begin
                st_q    <= ST_DATA;
                idx_q   <= '0;
                start_o <= 1'b1;
              end else begin
                st_q <= ST_IDLE;  // glitch, not a start bit
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (bit_end) begin
            cnt_q <= '0;
            sh_q  <= {rx_i, sh_q[CHAR_W-1:1]};
            if (idx_q == BW'(CHAR_W - 1)) st_q <= ST_MPB;
            else                          idx_q <= idx_q + 1'b1;
          end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_MPB: begin
          if (bit_end) begin
            cnt_q <= '0;
            mpb_q <= rx_i;
            st_q  <= ST_STOP;
          end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (bit_end) begin
            cnt_q  <= '0;
            stop_q <= rx_i;
            done_o <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign char_o = '{data: sh_q, mpb: mpb_q, stop_ok: stop_q};
endmodule

// File: rtl/mpu_rx_status.sv
module mpu_rx_status
  import mpu_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              done_i,
  input  rx_char_t          char_i,
  input  logic              mp_mode_i,
  input  logic              wake_set_i,
  input  logic              clr_i,
  output logic [CHAR_W-1:0] data_o,
  output logic              ready_o,
  output logic              fer_o,
  output logic              ovr_o,
  output logic              mpb_o,
  output logic              wake_en_o
);
  logic              gate_q;
  logic              accept;
  logic              wake_hit;
  logic [CHAR_W-1:0] data_d;
  logic              ready_d, fer_d, ovr_d, mpb_d, wake_d;

  // filtering decision frozen at frame start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gate_q <= 1'b0;
    else if (start_i) gate_q <= wake_en_o && mp_mode_i;
  end

  assign accept   = done_i && !(gate_q && !char_i.mpb);
  assign wake_hit = done_i && gate_q && char_i.mpb;

  always_comb begin
    data_d  = data_o;
    ready_d = clr_i ? 1'b0 : ready_o;
    fer_d   = clr_i ? 1'b0 : fer_o;
    ovr_d   = clr_i ? 1'b0 : ovr_o;
    mpb_d   = mpb_o;
    wake_d  = wake_en_o;
    if (accept) begin
      mpb_d = char_i.mpb;
      if (!char_i.stop_ok) begin
        fer_d = 1'b1;
      end else if (ready_d) begin
        ovr_d = 1'b1;
      end else begin
        data_d  = char_i.data;
        ready_d = 1'b1;
      end
    end
    if (wake_set_i)    wake_d = 1'b1;
    else if (wake_hit) wake_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      ready_o   <= 1'b0;
      fer_o     <= 1'b0;
      ovr_o     <= 1'b0;
      mpb_o     <= 1'b0;
      wake_en_o <= 1'b0;
    end else begin
      data_o    <= data_d;
      ready_o   <= ready_d;
      fer_o     <= fer_d;
      ovr_o     <= ovr_d;
      mpb_o     <= mpb_d;
      wake_en_o <= wake_d;
    end
  end
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
  import mpu_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              rx_en_i,
  input  logic              mp_mode_i,
  input  logic              wake_set_i,
  input  logic              rie_i,
  input  logic              clr_flags_i,
  output logic [CHAR_W-1:0] data_o,
  output logic              ready_o,
  output logic              fer_o,
  output logic              ovr_o,
  output logic              mpb_o,
  output logic              wake_en_o,
  output logic              rxi_o,
  output logic              eri_o
);
  logic     rx_s;
  logic     start_w;
  logic     done_w;
  rx_char_t char_w;

  mpu_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rx_i),
    .q_o    (rx_s)
  );

  mpu_rx_frame #(.OVS(OVS)) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rx_i    (rx_s),
    .tick_i  (tick_i),
    .en_i    (rx_en_i),
    .start_o (start_w),
    .done_o  (done_w),
    .char_o  (char_w)
  );

  mpu_rx_status u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_w),
    .done_i     (done_w),
    .char_i     (char_w),
    .mp_mode_i  (mp_mode_i),
    .wake_set_i (wake_set_i),
    .clr_i      (clr_flags_i),
    .data_o     (data_o),
    .ready_o    (ready_o),
    .fer_o      (fer_o),
    .ovr_o      (ovr_o),
    .mpb_o      (mpb_o),
    .wake_en_o  (wake_en_o)
  );

  assign rxi_o = rie_i & ready_o;
  assign eri_o = rie_i & (fer_o | ovr_o);
endmodule

// File: rtl/mp_uart_rx_chk.sv
module mp_uart_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rie_i,
  input logic       clr_i,
  input logic       done_i,
  input logic       stop_ok_i,
  input logic [7:0] data_i,
  input logic       ready_i,
  input logic       fer_i,
  input logic       ovr_i,
  input logic       mpb_i,
  input logic       wake_en_i,
  input logic       rxi_i,
  input logic       eri_i
);
  AST_WAKE_FALL_MPB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wake_en_i) |-> mpb_i); // R8

  AST_WAKE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_en_i && !done_i |=> wake_en_i); // R8

  AST_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i && $past(ready_i) && !$past(clr_i) |-> $stable(data_i)); // R5

  AST_CLR_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !done_i |=> !ready_i && !fer_i && !ovr_i); // R6

  AST_BAD_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !stop_ok_i && !wake_en_i |=> fer_i); // R4

  AST_IRQ_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rie_i |-> !rxi_i && !eri_i); // R11
endmodule

bind mp_uart_rx mp_uart_rx_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rie_i     (rie_i),
  .clr_i     (clr_flags_i),
  .done_i    (done_w),
  .stop_ok_i (char_w.stop_ok),
  .data_i    (data_o),
  .ready_i   (ready_o),
  .fer_i     (fer_o),
  .ovr_i     (ovr_o),
  .mpb_i     (mpb_o),
  .wake_en_i (wake_en_o),
  .rxi_i     (rxi_o),
  .eri_i     (eri_o)
);

// File: tb/mp_uart_rx_tb.sv
module mp_uart_rx_tb;
  localparam int OVS = 8;

  // data, mpb, stop, wake strobe before, exp ready, exp fer, exp data, exp wake, exp mpb
  typedef struct packed {
    logic [7:0] data;
    logic       mpb;
    logic       stop;
    logic       wset;
    logic       e_rdy;
    logic       e_fer;
    logic [7:0] e_data;
    logic       e_wake;
    logic       e_mpb;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{8'hA5, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'hA5, 1'b0, 1'b0},  // R2 plain
    '{8'h3C, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h3C, 1'b0, 1'b1},  // R12 mpb kept
    '{8'h55, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h3C, 1'b1, 1'b1},  // R7 dropped
    '{8'h0F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 1'b1, 1'b1},  // R7 bad stop dropped
    '{8'h81, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h81, 1'b0, 1'b1},  // R8 wake
    '{8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h81, 1'b0, 1'b0},  // R4 framing
    '{8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}   // R2 zero byte
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       rx_en = 1'b0;
  logic       mp_mode = 1'b0;
  logic       wset = 1'b0;
  logic       rie = 1'b0;
  logic       clr = 1'b0;
  logic [7:0] data;
  logic       ready, fer, ovr, mpb, wake, rxi, eri;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         all_done = 1'b0;

  always #10 clk = ~clk;

  mp_uart_rx #(.OVS(OVS)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rx_i        (rx),
    .tick_i      (1'b1),
    .rx_en_i     (rx_en),
    .mp_mode_i   (mp_mode),
    .wake_set_i  (wset),
    .rie_i       (rie),
    .clr_flags_i (clr),
    .data_o      (data),
    .ready_o     (ready),
    .fer_o       (fer),
    .ovr_o       (ovr),
    .mpb_o       (mpb),
    .wake_en_o   (wake),
    .rxi_o       (rxi),
    .eri_o       (eri)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_clr();
    clr = 1'b1; @(negedge clk); clr = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_wake();
    wset = 1'b1; @(negedge clk); wset = 1'b0; @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic m, input logic s, input bit mid_wake);
    rx = 1'b0; repeat (OVS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = d[i];
      if (mid_wake && i == 4) begin
        wset = 1'b1; @(negedge clk); wset = 1'b0;
        repeat (OVS - 1) @(negedge clk);
      end else begin
        repeat (OVS) @(negedge clk);
      end
    end
    rx = m; repeat (OVS) @(negedge clk);
    rx = s; repeat (OVS) @(negedge clk);
    rx = 1'b1; repeat (2 * OVS) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!all_done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "data", data, 8'h00);
    check("R1", "flags", {2'b0, ready, fer, ovr, mpb, wake, rxi | eri}, 8'h00);

    rx_en = 1'b1; mp_mode = 1'b1; rie = 1'b1;
    repeat (2 * OVS) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VEC[i];
      pulse_clr();
      if (v.wset) pulse_wake();
      send(v.data, v.mpb, v.stop, 1'b0);
      check("R2/R7", $sformatf("vec%0d ready", i), {7'b0, ready}, {7'b0, v.e_rdy});
      check("R4/R7", $sformatf("vec%0d fer", i), {7'b0, fer}, {7'b0, v.e_fer});
      check("R2/R7", $sformatf("vec%0d data", i), data, v.e_data);
      check("R8", $sformatf("vec%0d wake", i), {7'b0, wake}, {7'b0, v.e_wake});
      check("R12", $sformatf("vec%0d mpb", i), {7'b0, mpb}, {7'b0, v.e_mpb});
      check("R11", $sformatf("vec%0d rxi", i), {7'b0, rxi}, {7'b0, v.e_rdy});
    end

    // R6 clear strobe
    pulse_clr();
    check("R6", "flags after clear", {5'b0, ready, fer, ovr}, 8'h00);

    // R5 overrun
    send(8'h11, 1'b0, 1'b1, 1'b0);
    send(8'h22, 1'b0, 1'b1, 1'b0);
    check("R5", "ovr", {7'b0, ovr}, 8'h01);
    check("R5", "data kept", data, 8'h11);
    check("R11", "eri", {7'b0, eri}, 8'h01);
    rie = 1'b0; @(negedge clk);
    check("R11", "irqs masked", {6'b0, rxi, eri}, 8'h00);
    rie = 1'b1;

    // R3 disable keeps flags, blocks reception
    rx_en = 1'b0; repeat (4) @(negedge clk);
    check("R3", "flags held", {6'b0, ready, ovr}, 8'h03);
    pulse_clr();
    send(8'h77, 1'b0, 1'b1, 1'b0);
    check("R3", "no reception ready", {7'b0, ready}, 8'h00);
    check("R3", "no reception data", data, 8'h11);
    rx_en = 1'b1; repeat (OVS) @(negedge clk);

    // R2 short start glitch ignored
    rx = 1'b0; repeat (2) @(negedge clk); rx = 1'b1; repeat (2 * OVS) @(negedge clk);
    check("R2", "glitch no frame", {6'b0, ready, fer}, 8'h00);
    send(8'h96, 1'b0, 1'b1, 1'b0);
    check("R2", "after glitch data", data, 8'h96);

    // R9 multiprocessor mode off
    pulse_clr();
    mp_mode = 1'b0;
    pulse_wake();
    send(8'h5A, 1'b0, 1'b1, 1'b0);
    check("R9", "accepted data", data, 8'h5A);
    check("R9", "wake kept", {7'b0, wake}, 8'h01);
    mp_mode = 1'b1;
    pulse_clr();
    send(8'h42, 1'b1, 1'b1, 1'b0);
    check("R8", "wake cleared", {7'b0, wake}, 8'h00);
    check("R8", "wake char data", data, 8'h42);

    // R10 wake strobe mid-frame applies from next frame
    pulse_clr();
    send(8'h6B, 1'b0, 1'b1, 1'b1);
    check("R10", "mid-frame wake set", {7'b0, wake}, 8'h01);
    check("R10", "in-flight char accepted", data, 8'h6B);
    pulse_clr();
    send(8'h19, 1'b0, 1'b1, 1'b0);
    check("R10", "next char filtered ready", {7'b0, ready}, 8'h00);
    check("R10", "next char filtered data", data, 8'h6B);

    all_done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule